// File: doc/BRIEF.md
# Parity-Checked Reversible Gate Bank

This block evaluates four three-wire reversible gates side by side on one shared 3-bit input vector. Three of the gates keep the XOR parity of their outputs equal to that of their inputs. The fourth, a doubly-controlled inverter, is one-to-one but changes parity for some inputs. Every gate's output word is registered, along with the parity of the input, the parity of each gate's output and a per-gate mismatch flag.

A parity-protected datapath built from such gates can compare input parity with output parity to catch a corrupted wire. This bank supplies that comparison for each gate. It is also a reference model against which a netlist of reversible cells can be checked vector by vector. In the bank, the doubly-controlled inverter is the gate whose flag must fire, and it serves as a known positive.

Bit order used throughout: `vec_in[2]` is the first input A, `vec_in[1]` is B and `vec_in[0]` is C. In each 3-bit output word, bit 2 is the first output P, bit 1 is Q and bit 0 is R. In the 4-bit per-gate vectors, bit 0 is the swap gate, bit 1 the fan-out gate, bit 2 the universal gate and bit 3 the doubly-controlled inverter.

Top module: `revgate_parity_bank`

## Requirements
- R1: When `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: Outside reset, every output reflects `vec_in` as it was at the previous rising edge (one register of latency).
- R3: Swap gate: P = A. When A = 0, Q = B and R = C. When A = 1, Q = C and R = B.
- R4: Fan-out gate: P = A, Q = A xor B, R = A xor C. With B = C = 0, all three outputs equal A.
- R5: Universal gate: P = A xor B, Q = (not B and C) xor (A and not C), R = (B and C) xor (A and not C).
- R6: Doubly-controlled inverter: P = A, Q = B, R = C xor (A and B).
- R7: Each of the four gates maps the 8 input vectors onto 8 distinct output words.
- R8: `par_in` equals A xor B xor C, and `par_out[i]` equals the XOR of gate i's three output bits.
- R9: `par_err[i]` equals `par_in` xor `par_out[i]`. Bits 0 to 2 are never set, and bit 3 is set exactly when A and B are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vec_in | input | 3 | Shared gate input {A,B,C} |
| swap_out | output | 3 | Registered swap-gate output {P,Q,R} |
| fan_out | output | 3 | Registered fan-out-gate output {P,Q,R} |
| univ_out | output | 3 | Registered universal-gate output {P,Q,R} |
| ccnot_out | output | 3 | Registered doubly-controlled-inverter output {P,Q,R} |
| par_in | output | 1 | Registered XOR parity of the input |
| par_out | output | 4 | Registered XOR parity of each gate's output |
| par_err | output | 4 | Registered per-gate parity mismatch flag |

## Verification
On every cycle, the assertions check the clearing by reset and three timing-relative properties. The swap gate's pass/exchange rule and the inverter's target bit are checked against the input of the previous cycle. The flags are checked too: the three parity-keeping gates must never raise a mismatch, and the inverter's flag must track A and B from the prior cycle. The one-to-one property cannot be seen in a single cycle, because it concerns all eight inputs taken together. Only the bench's exhaustive sweep can show it, where it records which output words each gate has already produced. The exact truth tables of the fan-out and universal gates are confirmed by that sweep and by seeded random vectors.

// File: rtl/revgate_pkg.sv
package revgate_pkg;

  localparam int GW        = 3;
  localparam int NUM_GATES = 4;

  typedef enum logic [1:0] {
    G_SWAP  = 2'd0,
    G_FAN   = 2'd1,
    G_UNIV  = 2'd2,
    G_CCNOT = 2'd3
  } gate_kind_e;

  function automatic gate_kind_e kind_of(input int idx);
    case (idx)
      0:       return G_SWAP;
      1:       return G_FAN;
      2:       return G_UNIV;
      default: return G_CCNOT;
    endcase
  endfunction

  // Control on bit 2; the two data wires exchange when it is high.
  function automatic logic [GW-1:0] f_swap(input logic [GW-1:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {a, (a ? c : b), (a ? b : c)};
  endfunction

  function automatic logic [GW-1:0] f_fan(input logic [GW-1:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {a, a ^ b, a ^ c};
  endfunction

  function automatic logic [GW-1:0] f_univ(input logic [GW-1:0] v);
    logic a, b, c, t;
    {a, b, c} = v;
    t = a & ~c;
    return {a ^ b, (~b & c) ^ t, (b & c) ^ t};
  endfunction

  function automatic logic [GW-1:0] f_ccnot(input logic [GW-1:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {a, b, c ^ (a & b)};
  endfunction

endpackage

// File: rtl/revgate_lane.sv
module revgate_lane
  import revgate_pkg::*;
#(
  parameter gate_kind_e KIND = G_SWAP
) (
  input  logic [GW-1:0] v,
  output logic [GW-1:0] y
);

  generate
    if (KIND == G_SWAP) begin : g_swap
      always_comb y = f_swap(v);
    end else if (KIND == G_FAN) begin : g_fan
      always_comb y = f_fan(v);
    end else if (KIND == G_UNIV) begin : g_univ
      always_comb y = f_univ(v);
    end else begin : g_ccnot
      always_comb y = f_ccnot(v);
    end
  endgenerate

endmodule

// File: rtl/parity_probe.sv
module parity_probe #(
  parameter int W = 3
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic         src_par,
  output logic         dst_par,
  output logic         mismatch
);

  always_comb begin
    src_par  = ^src;
    dst_par  = ^dst;
    mismatch = src_par ^ dst_par;
  end

endmodule

// File: rtl/revgate_parity_bank.sv
module revgate_parity_bank
  import revgate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GW-1:0]        vec_in,
  output logic [GW-1:0]        swap_out,
  output logic [GW-1:0]        fan_out,
  output logic [GW-1:0]        univ_out,
  output logic [GW-1:0]        ccnot_out,
  output logic                 par_in,
  output logic [NUM_GATES-1:0] par_out,
  output logic [NUM_GATES-1:0] par_err
);

  logic [GW-1:0]        lane_y  [NUM_GATES];
  logic [GW-1:0]        lane_q  [NUM_GATES];
  logic [NUM_GATES-1:0] src_par_c;
  logic [NUM_GATES-1:0] dst_par_c;
  logic [NUM_GATES-1:0] err_c;

  for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_lane
    revgate_lane #(.KIND(kind_of(gi))) u_gate (
      .v (vec_in),
      .y (lane_y[gi])
    );

    parity_probe #(.W(GW)) u_probe (
      .src      (vec_in),
      .dst      (lane_y[gi]),
      .src_par  (src_par_c[gi]),
      .dst_par  (dst_par_c[gi]),
      .mismatch (err_c[gi])
    );

    always_ff @(posedge clk) begin
      if (rst) lane_q[gi] <= '0;
      else     lane_q[gi] <= lane_y[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_in  <= 1'b0;
      par_out <= '0;
      par_err <= '0;
    end else begin
      par_in  <= src_par_c[0];
      par_out <= dst_par_c;
      par_err <= err_c;
    end
  end

  always_comb begin
    swap_out  = lane_q[0];
    fan_out   = lane_q[1];
    univ_out  = lane_q[2];
    ccnot_out = lane_q[3];
  end

endmodule

// File: rtl/revgate_parity_bank_chk.sv
module revgate_parity_bank_chk
  import revgate_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [GW-1:0]        vec_in,
  input logic [GW-1:0]        swap_out,
  input logic [GW-1:0]        fan_out,
  input logic [GW-1:0]        univ_out,
  input logic [GW-1:0]        ccnot_out,
  input logic                 par_in,
  input logic [NUM_GATES-1:0] par_out,
  input logic [NUM_GATES-1:0] par_err
);

  // High once the previous edge was a non-reset edge.
  logic live_q = 1'b0;
  always_ff @(posedge clk) live_q <= !rst;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (swap_out == '0 && fan_out == '0 && univ_out == '0 &&
             ccnot_out == '0 && !par_in && par_out == '0 && par_err == '0));

  p_swap_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(vec_in[2])) |-> swap_out == $past(vec_in));

  p_swap_cross_r3: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(vec_in[2])) |->
      swap_out == {1'b1, $past(vec_in[0]), $past(vec_in[1])});

  p_ccnot_target_r6: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ccnot_out[0] == ($past(vec_in[0]) ^ ($past(vec_in[2]) & $past(vec_in[1]))));

  p_keep_parity_r9: assert property (@(posedge clk) disable iff (rst)
    par_err[2:0] == 3'b000);

  p_ccnot_flag_r9: assert property (@(posedge clk) disable iff (rst)
    live_q |-> par_err[3] == ($past(vec_in[2]) & $past(vec_in[1])));

endmodule

bind revgate_parity_bank revgate_parity_bank_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .vec_in    (vec_in),
  .swap_out  (swap_out),
  .fan_out   (fan_out),
  .univ_out  (univ_out),
  .ccnot_out (ccnot_out),
  .par_in    (par_in),
  .par_out   (par_out),
  .par_err   (par_err)
);

// File: tb/test_revgate_parity_bank.sv
module test_revgate_parity_bank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] vec_in = 3'b000;
  logic [2:0] swap_out, fan_out, univ_out, ccnot_out;
  logic       par_in;
  logic [3:0] par_out, par_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  revgate_parity_bank i_revgate_parity_bank (
    .clk       (clk),
    .rst       (rst),
    .vec_in    (vec_in),
    .swap_out  (swap_out),
    .fan_out   (fan_out),
    .univ_out  (univ_out),
    .ccnot_out (ccnot_out),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_err   (par_err)
  );

  function automatic logic [2:0] exp_swap(input logic [2:0] v);
    if (v[2]) return {1'b1, v[0], v[1]};
    return v;
  endfunction

  function automatic logic [2:0] exp_fan(input logic [2:0] v);
    return {v[2], v[2] ^ v[1], v[2] ^ v[0]};
  endfunction

  function automatic logic [2:0] exp_univ(input logic [2:0] v);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    return {a ^ b, (!b && c) ^ (a && !c), (b && c) ^ (a && !c)};
  endfunction

  function automatic logic [2:0] exp_ccnot(input logic [2:0] v);
    return {v[2], v[1], v[0] ^ (v[2] & v[1])};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on falling edge, let one rising edge register it, sample on next falling edge.
  task automatic apply(input logic [2:0] v);
    vec_in = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input logic [2:0] v);
    logic [3:0] eo, ee;
    eo = {^exp_ccnot(v), ^exp_univ(v), ^exp_fan(v), ^exp_swap(v)};
    ee = eo ^ {4{^v}};
    check("R2 R3 swap", {13'd0, swap_out}, {13'd0, exp_swap(v)});
    check("R2 R4 fan", {13'd0, fan_out}, {13'd0, exp_fan(v)});
    check("R2 R5 univ", {13'd0, univ_out}, {13'd0, exp_univ(v)});
    check("R2 R6 ccnot", {13'd0, ccnot_out}, {13'd0, exp_ccnot(v)});
    check("R8 parity", {11'd0, par_in, par_out}, {11'd0, ^v, eo});
    check("R9 flags", {12'd0, par_err}, {12'd0, ee});
    check("R9 ccnot flag", {15'd0, par_err[3]}, {15'd0, v[2] & v[1]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] seen [4];
    logic [2:0] outs [4];
    int unused_seed;
    rst = 1'b1;
    vec_in = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with a nonzero input present
    check("R1 reset outs", {4'd0, swap_out, fan_out, univ_out, ccnot_out}, 16'd0);
    check("R1 reset flags", {7'd0, par_in, par_out, par_err}, 16'd0);
    rst = 1'b0;

    // Exhaustive sweep, also gathering the bijection evidence (R7)
    for (int g = 0; g < 4; g++) seen[g] = 8'd0;
    for (int i = 0; i < 8; i++) begin
      apply(3'(i));
      check_all(3'(i));
      outs[0] = swap_out; outs[1] = fan_out; outs[2] = univ_out; outs[3] = ccnot_out;
      for (int g = 0; g < 4; g++) begin
        check("R7 distinct", {15'd0, seen[g][outs[g]]}, 16'd0);
        seen[g][outs[g]] = 1'b1;
      end
    end
    for (int g = 0; g < 4; g++) check("R7 onto", {8'd0, seen[g]}, 16'h00ff);

    // R4: copy mode with B = C = 0
    apply(3'b100);
    check("R4 copy one", {13'd0, fan_out}, 16'd7);
    apply(3'b000);
    check("R4 copy zero", {13'd0, fan_out}, 16'd0);

    // Seeded random vectors
    unused_seed = $urandom(32'd1234);
    for (int k = 0; k < 300; k++) begin
      logic [2:0] r;
      r = 3'($urandom);
      apply(r);
      check_all(r);
    end

    // R1: reset in the middle of traffic clears the registered results
    apply(3'b110);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid reset", {4'd0, swap_out, fan_out, univ_out, ccnot_out}, 16'd0);
    check("R1 mid reset flags", {7'd0, par_in, par_out, par_err}, 16'd0);
    rst = 1'b0;
    apply(3'b110);
    check_all(3'b110);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule